// File: doc/BRIEF.md
# Dual-Condition Key Interrupt Generator

This block produces the interrupt request for a queue of debounced key events. The request can be raised by either of two sources. A timer counts debounce-cycle ticks after the most recent key event. A fill comparator watches how many events are waiting in the queue. The first source to be satisfied raises the request. The request drives an active-low, open-drain pin, which is modelled here as a single drive-enable output: 1 pulls the pin low, 0 leaves it floating.

An 8-bit interrupt configuration byte controls both sources. Its low five bits give the tick count, and its top three bits give a code for the fill threshold. When the whole byte is zero, the pin no longer carries the interrupt. It becomes a general-purpose open-drain output that follows one port-register bit. A clear-mode input selects how the request is withdrawn: either on any queue read, or only once the queue is empty.

The queue and the host bus are outside this block. Only the event strobe, the tick, the queue count and the read strobe reach it.

Top module: `kint_irq_gen`

## Requirements
- R1: With `int_cfg[4:0]` = N (1..31), the interrupt is raised on the clock edge that samples the N-th `db_tick` counted after the latest `key_evt`. `pin_oe` reads 1 from that edge on. A tick in the same cycle as an event is not counted.
- R2: A new `key_evt` restarts the tick count from zero, including while a count is already running.
- R3: With `int_cfg[7:5]` = c (1..7), the interrupt is raised on the edge that samples `fifo_cnt` >= 2*c.
- R4: A zero tick field disables the time source, and a zero code disables the fill source, provided the other field is nonzero.
- R5: When both sources are enabled, whichever is met first raises the interrupt.
- R6: With `clr_on_empty` = 0, an edge that samples `fifo_rd` = 1 clears the interrupt when no source is raising it in that cycle.
- R7: With `clr_on_empty` = 1, reads do not clear the interrupt. It clears on the edge that samples `fifo_cnt` = 0.
- R8: A raise and a clear that fall in the same cycle leave the interrupt asserted.
- R9: With `int_cfg` = 0x00, `pin_oe` equals the inverse of `gpo_level` in the same cycle. Events, ticks and the queue count have no effect on the pin. The interrupt state is cleared.
- R10: During reset and after it, `pin_oe` is 0 while the configuration is nonzero. No time count is running.
- R11: The time source fires once per event. Further ticks raise nothing until the next `key_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_evt | input | 1 | One-cycle strobe: a key event was queued |
| db_tick | input | 1 | One-cycle strobe at the end of each debounce cycle |
| fifo_cnt | input | CNT_W | Number of events stored in the queue |
| fifo_rd | input | 1 | One-cycle strobe: the host read the queue |
| int_cfg | input | CFG_W | [4:0] tick count, [7:5] fill-threshold code |
| clr_on_empty | input | 1 | 0: clear on read, 1: clear when the queue is empty |
| gpo_level | input | 1 | Port-register bit that sets the pin level in output mode |
| pin_oe | output | 1 | Drive enable: 1 pulls the open-drain pin low |

## Verification
Within one cycle, a source can raise the interrupt while a clear condition withdraws it. Examples are a read strobe that arrives while the count is still at or above the threshold, and the N-th tick that lands together with a read. Directed cases build both of these collisions on purpose. The random phase produces many more by driving reads, ticks and count changes independently. A bench model that gives the raise priority judges every cycle, and the correct result is that `pin_oe` stays at 1.

// File: rtl/kint_pkg.sv
package kint_pkg;
  // fill threshold in stored events for a 3-bit code; code 0 means off
  function automatic int unsigned fill_threshold(input logic [2:0] code);
    return 2 * int'(code);
  endfunction

  // withdraw condition chosen by the clear mode
  function automatic logic clear_request(input logic on_empty,
                                         input logic queue_empty,
                                         input logic rd);
    return on_empty ? queue_empty : rd;
  endfunction
endpackage

// File: rtl/kint_tmr.sv
module kint_tmr #(
  parameter int TIME_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [TIME_W-1:0] limit,
  input  logic              key_evt,
  input  logic              db_tick,
  output logic              time_hit,
  output logic              armed
);
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign time_hit = enable && (limit != '0) && armed && db_tick && !key_evt
                    && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (!enable) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (key_evt) begin
      armed <= 1'b1;
      cnt_q <= '0;
    end else if (time_hit) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (armed && db_tick && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: an event restarts the count from zero
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && key_evt) |=> (armed && cnt_q == '0));
  // R11: the time source disarms once it has fired
  p_one_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (time_hit && enable) |=> !armed);
endmodule

// File: rtl/kint_fill.sv
module kint_fill #(
  parameter int CNT_W  = 5,
  parameter int CODE_W = 3
) (
  input  logic              enable,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic [CODE_W-1:0] code,
  output logic              fill_hit
);
  import kint_pkg::*;
  logic [CNT_W:0] thr;

  assign thr      = (CNT_W+1)'(fill_threshold(3'(code)));
  assign fill_hit = enable && (code != '0) && ({1'b0, fifo_cnt} >= thr);
endmodule

// File: rtl/kint_latch.sv
module kint_latch #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gpo_mode,
  input  logic             time_hit,
  input  logic             fill_hit,
  input  logic             clr_on_empty,
  input  logic             fifo_rd,
  input  logic [CNT_W-1:0] fifo_cnt,
  output logic             irq_q
);
  import kint_pkg::*;
  logic raise, withdraw;

  assign raise    = time_hit || fill_hit;
  assign withdraw = clear_request(clr_on_empty, fifo_cnt == '0, fifo_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (gpo_mode) irq_q <= 1'b0;
    else if (raise)    irq_q <= 1'b1;
    else if (withdraw) irq_q <= 1'b0;
  end

  p_time_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (time_hit && !gpo_mode) |=> irq_q);
  p_fill_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_hit && !gpo_mode) |=> irq_q);
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_on_empty && fifo_rd && !raise) |=> !irq_q);
  p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_empty && fifo_cnt == '0 && !raise) |=> !irq_q);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && withdraw && !gpo_mode) |=> irq_q);
  p_gpo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gpo_mode |=> !irq_q);
endmodule

// File: rtl/kint_irq_gen.sv
module kint_irq_gen #(
  parameter int CFG_W  = 8,
  parameter int TIME_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_evt,
  input  logic             db_tick,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  logic             fifo_rd,
  input  logic [CFG_W-1:0] int_cfg,
  input  logic             clr_on_empty,
  input  logic             gpo_level,
  output logic             pin_oe
);
  localparam int CODE_W = CFG_W - TIME_W;

  logic              gpo_mode, time_hit, fill_hit, armed, irq_q;
  logic [TIME_W-1:0] tick_limit;
  logic [CODE_W-1:0] fill_code;

  assign tick_limit = int_cfg[TIME_W-1:0];
  assign fill_code  = int_cfg[CFG_W-1:TIME_W];
  assign gpo_mode   = (int_cfg == '0);

  kint_tmr #(.TIME_W(TIME_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .enable(!gpo_mode), .limit(tick_limit),
    .key_evt(key_evt), .db_tick(db_tick), .time_hit(time_hit), .armed(armed));

  kint_fill #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_fill (
    .enable(!gpo_mode), .fifo_cnt(fifo_cnt), .code(fill_code),
    .fill_hit(fill_hit));

  kint_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .gpo_mode(gpo_mode), .time_hit(time_hit),
    .fill_hit(fill_hit), .clr_on_empty(clr_on_empty), .fifo_rd(fifo_rd),
    .fifo_cnt(fifo_cnt), .irq_q(irq_q));

  assign pin_oe = gpo_mode ? !gpo_level : irq_q;

  // R10: no count runs straight out of reset
  p_idle_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !armed);
  // R4: a zero tick field never yields a timed raise
  p_time_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_limit == '0) |-> !time_hit);
endmodule

// File: tb/tb_kint_irq_gen.sv
module tb_kint_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_evt = 0, db_tick = 0, fifo_rd = 0, clr_on_empty = 0, gpo_level = 1;
  logic [4:0] fifo_cnt = '0;
  logic [7:0] int_cfg = 8'h03;
  logic       pin_oe;

  int n_chk = 0, n_bad = 0;
  string tag = "R10";

  // reference state
  logic       m_irq = 0, m_armed = 0;
  int         m_cnt = 0;

  always #5 clk = ~clk;

  kint_irq_gen dut (.clk(clk), .rst_n(rst_n), .key_evt(key_evt), .db_tick(db_tick),
    .fifo_cnt(fifo_cnt), .fifo_rd(fifo_rd), .int_cfg(int_cfg),
    .clr_on_empty(clr_on_empty), .gpo_level(gpo_level), .pin_oe(pin_oe));

  function automatic int thr_of(input logic [7:0] c);
    return (c >> 5) * 2;
  endfunction

  function automatic logic exp_pin();
    return (int_cfg == 8'h00) ? !gpo_level : m_irq;
  endfunction

  task automatic model_edge();
    bit gm = (int_cfg == 0);
    int n = int_cfg[4:0];
    bit th = !gm && n != 0 && m_armed && db_tick && !key_evt && (m_cnt + 1 >= n);
    bit fh = !gm && thr_of(int_cfg) != 0 && int'(fifo_cnt) >= thr_of(int_cfg);
    bit cl = clr_on_empty ? (fifo_cnt == 0) : fifo_rd;
    if (gm) m_irq = 0; else if (th || fh) m_irq = 1; else if (cl) m_irq = 0;
    if (gm) begin m_armed = 0; m_cnt = 0; end
    else if (key_evt) begin m_armed = 1; m_cnt = 0; end
    else if (th) begin m_armed = 0; m_cnt = 0; end
    else if (m_armed && db_tick && m_cnt != 31) m_cnt++;
  endtask

  task automatic check(input string t, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pin_oe=%0b expected %0b at %0t", t, got, exp, $time);
    end
  endtask

  // one clock: model updates at the edge, comparison at the falling edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst_n) model_edge();
      @(negedge clk);
      check(tag, pin_oe, exp_pin());
    end
  endtask

  task automatic pulse_evt();  key_evt = 1; step(); key_evt = 0; endtask
  task automatic pulse_tick(); db_tick = 1; step(); db_tick = 0; step(); endtask
  task automatic pulse_rd();   fifo_rd = 1; step(); fifo_rd = 0; endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", pin_oe, 1'b0);
    rst_n = 1; step(3);
    check("R10", pin_oe, 1'b0);

    // R1: three ticks after one event
    tag = "R1"; int_cfg = 8'h03;
    pulse_evt(); pulse_tick(); pulse_tick();
    check("R1", pin_oe, 1'b0);
    db_tick = 1; step(); db_tick = 0;
    check("R1", pin_oe, 1'b1);
    // R6 clear on read
    tag = "R6"; pulse_rd();
    check("R6", pin_oe, 1'b0);
    // R11 no second firing without an event
    tag = "R11"; repeat (5) pulse_tick();
    check("R11", pin_oe, 1'b0);
    // R2 restart
    tag = "R2"; pulse_evt(); pulse_tick(); pulse_tick(); pulse_evt();
    pulse_tick(); pulse_tick();
    check("R2", pin_oe, 1'b0);
    pulse_tick();
    check("R2", pin_oe, 1'b1);
    pulse_rd();

    // R3: code 3 -> six events
    tag = "R3"; int_cfg = 8'h60; fifo_cnt = 5; step(2);
    check("R3", pin_oe, 1'b0);
    fifo_cnt = 6; step();
    check("R3", pin_oe, 1'b1);
    // R8 read while still at threshold: stays raised
    tag = "R8"; pulse_rd();
    check("R8", pin_oe, 1'b1);
    fifo_cnt = 2; pulse_rd();
    check("R6", pin_oe, 1'b0);

    // R4: code 0 with a full queue, tick field 0 with events
    tag = "R4"; int_cfg = 8'h02; fifo_cnt = 16; step(3);
    check("R4", pin_oe, 1'b0);
    int_cfg = 8'h20; fifo_cnt = 1; pulse_evt(); repeat (40) pulse_tick();
    check("R4", pin_oe, 1'b0);

    // R5: both on, fill threshold 4 reached before five ticks
    tag = "R5"; int_cfg = 8'h45; fifo_cnt = 0; pulse_evt(); pulse_tick();
    fifo_cnt = 4; step();
    check("R5", pin_oe, 1'b1);
    // R7 clear only on empty
    tag = "R7"; clr_on_empty = 1; fifo_cnt = 3; pulse_rd();
    check("R7", pin_oe, 1'b1);
    fifo_cnt = 0; step();
    check("R7", pin_oe, 1'b0);
    // R8: fifth tick together with a read in read-clear mode
    tag = "R8"; clr_on_empty = 0; fifo_cnt = 1; pulse_evt();
    repeat (4) pulse_tick();
    db_tick = 1; fifo_rd = 1; step(); db_tick = 0; fifo_rd = 0;
    check("R8", pin_oe, 1'b1);
    pulse_rd();

    // R9 output mode
    tag = "R9"; int_cfg = 8'h00; gpo_level = 0; fifo_cnt = 16; key_evt = 1; db_tick = 1;
    step(); check("R9", pin_oe, 1'b1);
    gpo_level = 1; step(); check("R9", pin_oe, 1'b0);
    key_evt = 0; db_tick = 0;
    int_cfg = 8'h01; fifo_cnt = 0; step();
    check("R9", pin_oe, 1'b0);

    // random mix, every cycle compared against the model
    tag = "RAND";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        case ($urandom_range(0, 4))
          0: int_cfg = 8'h00;
          1: int_cfg = 8'($urandom_range(1, 31));
          2: int_cfg = 8'($urandom_range(1, 7) << 5);
          default: int_cfg = 8'($urandom_range(1, 255));
        endcase
        clr_on_empty = 1'($urandom_range(0, 1));
      end
      key_evt   = ($urandom_range(0, 19) == 0);
      db_tick   = ($urandom_range(0, 2) == 0);
      fifo_rd   = ($urandom_range(0, 9) == 0);
      gpo_level = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin
        if (fifo_rd && fifo_cnt != 0) fifo_cnt = fifo_cnt - 1;
        else if (fifo_cnt < 16) fifo_cnt = fifo_cnt + 1;
      end
      step();
    end
    key_evt = 0; db_tick = 0; fifo_rd = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule